// File: doc/BRIEF.md
# Serial Audio Bit-Clock and Frame-Sync Generator

This block makes the timing for a serial audio port. It divides a fast input clock by a programmable 8-bit value to produce a bit clock. It then counts bit clocks to produce a frame-sync pulse whose width and period are programmed in bit clocks. It also raises a one-cycle frame-start strobe whenever a new frame opens. The bit clock is given two ways: as a level, and as an enable strobe that lasts one input-clock cycle and marks each bit-clock period. A shifter downstream uses the enable strobe to move data one bit at a time.

All settings come from one 32-bit configuration word. Bits [7:0] hold the divider. Bits [15:8] hold the frame-sync width minus one. Bits [27:16] hold the frame period minus one. Bit 28 is the periodic-mode bit. Bit 29 is a clock-source select that has no effect inside this block. Two run bits control the block. `gen_run` releases the divider. `fs_run` releases frame-sync generation, and it takes effect only while the divider is running. A polarity input chooses whether the frame-sync output is active high or active low. When the periodic-mode bit is clear, one frame-sync pulse is issued for each `data_load` strobe instead of on a free-running schedule.

The controller has five states:
- HALT: the divider is stopped.
- CLOCK: the bit clock runs and frame sync is held inactive.
- FRAME: periodic framing.
- ARMED: one-shot mode, waiting for a load.
- SHOT: one one-shot pulse is in progress.

The transitions are:
- HALT→CLOCK when `gen_run` rises.
- CLOCK→FRAME or CLOCK→ARMED when `fs_run` is set, chosen by the periodic-mode bit.
- FRAME↔ARMED when the periodic-mode bit changes.
- ARMED→SHOT on `data_load`.
- SHOT→ARMED on the bit-clock tick that ends the pulse.
- Any state→CLOCK when `fs_run` drops.
- Any state→HALT when `gen_run` drops.

Top module: `audio_clkgen`

## Requirements
- R1: While `rst_n` is low, or one cycle after `gen_run` is low, `bclk_en`, `bclk` and `frame_start` are 0 and `fsync` sits at its inactive level.
- R2: While running, `bclk_en` is high for one cycle out of every (div+1) input-clock cycles, where div is `cfg_word[7:0]`. With div = 0 it is high on every cycle.
- R3: `bclk` is high for (div>>1)+1 input-clock cycles of each (div+1)-cycle bit period and low for the rest. It is 0 while the generator is stopped.
- R4: In periodic mode (`cfg_word[28]` = 1), `frame_start` repeats every (P+1) bit clocks, where P is `cfg_word[27:16]`. Frame sizes from 33 up to 4095 bit clocks work.
- R5: `fsync` is active for (W+1) bit clocks, that is (W+1)·(div+1) input cycles, starting at each frame start. W is `cfg_word[15:8]`.
- R6: `fs_pol` = 0 makes `fsync` active high and `fs_pol` = 1 makes it active low. When no pulse is in progress, `fsync` equals `fs_pol`.
- R7: `frame_start` lasts exactly one input-clock cycle (when div ≠ 0). `fsync` is active in that same cycle.
- R8: `fs_run` produces no frame sync while `gen_run` is low. Framing starts once the generator is running.
- R9: With `cfg_word[28]` = 0, no frame sync appears without a load. Each one-cycle `data_load` produces exactly one `frame_start` and one (W+1)-bit-clock pulse.
- R10: When `fs_run` goes low, `fsync` is inactive and `frame_start` is 0 from the next cycle on, while `bclk_en` keeps running.
- R11: `cfg_word[29]` has no effect on the bit clock or on frame timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 32 | Divider, width, period, periodic-mode and source-select fields |
| gen_run | input | 1 | 1 releases the divider |
| fs_run | input | 1 | 1 releases frame-sync generation |
| fs_pol | input | 1 | Frame-sync polarity: 0 active high, 1 active low |
| data_load | input | 1 | One-shot trigger used when periodic mode is off |
| bclk | output | 1 | Bit-clock level |
| bclk_en | output | 1 | One-cycle strobe per bit-clock period |
| fsync | output | 1 | Frame-sync level after polarity |
| frame_start | output | 1 | One-cycle strobe at the opening of each frame |

## Verification
The hardest case to reach is the one-shot path at its boundaries. The bench must show that an armed generator stays silent for a long stretch, then gives exactly one pulse of the right length after a single load, and then falls silent again. Reaching it takes two steps in order: release the divider with the periodic-mode bit clear, then raise `fs_run`. The bench then observes several hundred cycles before the load and again after the pulse. The extreme frame size of 4095 bit clocks comes next in difficulty. It is reached with div = 0, so one full frame fits within a few thousand cycles.

// File: rtl/audio_clkgen_pkg.sv
package audio_clkgen_pkg;

    // Default field widths inside the configuration word
    parameter int DIV_W_D = 8;
    parameter int WID_W_D = 8;
    parameter int PER_W_D = 12;
    parameter int CFG_W_D = 32;

    // Controller states
    typedef enum logic [2:0] {
        ST_HALT  = 3'd0,   // divider stopped
        ST_CLOCK = 3'd1,   // bit clock only
        ST_FRAME = 3'd2,   // periodic framing
        ST_ARMED = 3'd3,   // one-shot, waiting for a load
        ST_SHOT  = 3'd4    // one-shot pulse in progress
    } fs_state_e;

endpackage

// File: rtl/acg_divider.sv
module acg_divider #(
    parameter int DIV_W = audio_clkgen_pkg::DIV_W_D
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick,
    output logic             level
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] half;

    assign half = div >> 1;

    // Counter runs 0..div, then wraps; held at zero while stopped
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q >= div) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Tick on the last cycle of each bit period
    assign tick  = run && (cnt_q >= div);
    // High for the first half of the period (rounded up)
    assign level = run && (cnt_q <= half);

endmodule

// File: rtl/acg_frame_seq.sv
module acg_frame_seq
    import audio_clkgen_pkg::*;
#(
    parameter int WID_W = WID_W_D,
    parameter int PER_W = PER_W_D
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gen_run,
    input  logic             fs_run,
    input  logic             periodic,
    input  logic             load,
    input  logic             tick,
    input  logic [WID_W-1:0] width,
    input  logic [PER_W-1:0] period,
    output logic             clk_on,
    output logic             fs_act,
    output logic             frame_start
);
    fs_state_e        st_q, st_d;
    logic [PER_W-1:0] pos_q;
    logic [PER_W-1:0] width_ext;
    logic             act_q;
    logic             fstart_q;
    logic             enabled;
    logic             last_bit;

    // Width field widened to the position counter
    generate
        if (PER_W > WID_W) begin : g_wext
            assign width_ext = {{(PER_W-WID_W){1'b0}}, width};
        end else begin : g_wtrunc
            assign width_ext = width[PER_W-1:0];
        end
    endgenerate

    assign enabled  = gen_run && fs_run;
    assign last_bit = (pos_q == width_ext);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_HALT;
        end else begin
            st_q <= st_d;
        end
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HALT: begin
                if (gen_run) st_d = ST_CLOCK;
            end
            ST_CLOCK: begin
                if (!gen_run)    st_d = ST_HALT;
                else if (fs_run) st_d = periodic ? ST_FRAME : ST_ARMED;
            end
            ST_FRAME: begin
                if (!gen_run)      st_d = ST_HALT;
                else if (!fs_run)  st_d = ST_CLOCK;
                else if (!periodic) st_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (!gen_run)     st_d = ST_HALT;
                else if (!fs_run) st_d = ST_CLOCK;
                else if (periodic) st_d = ST_FRAME;
                else if (load)    st_d = ST_SHOT;
            end
            ST_SHOT: begin
                if (!gen_run)              st_d = ST_HALT;
                else if (!fs_run)          st_d = ST_CLOCK;
                else if (tick && last_bit) st_d = ST_ARMED;
            end
            default: st_d = ST_HALT;
        endcase
    end

    // Output and position process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q    <= '0;
            act_q    <= 1'b0;
            fstart_q <= 1'b0;
        end else if (!enabled || st_q == ST_HALT || st_q == ST_CLOCK) begin
            pos_q    <= '0;
            act_q    <= 1'b0;
            fstart_q <= 1'b0;
        end else begin
            fstart_q <= 1'b0;
            unique case (st_q)
                ST_FRAME: begin
                    if (tick) begin
                        act_q    <= (pos_q <= width_ext);
                        fstart_q <= (pos_q == '0);
                        pos_q    <= (pos_q >= period) ? '0 : pos_q + 1'b1;
                    end
                    if (!periodic) pos_q <= '0;
                end
                ST_ARMED: begin
                    pos_q <= '0;
                    if (tick) act_q <= 1'b0;
                end
                ST_SHOT: begin
                    if (tick) begin
                        act_q    <= 1'b1;
                        fstart_q <= (pos_q == '0);
                        pos_q    <= last_bit ? '0 : pos_q + 1'b1;
                    end
                end
                default: begin
                    pos_q <= '0;
                end
            endcase
        end
    end

    assign clk_on      = (st_q != ST_HALT);
    assign fs_act      = act_q;
    assign frame_start = fstart_q;

endmodule

// File: rtl/acg_fs_drive.sv
module acg_fs_drive (
    input  logic act,
    input  logic pol,
    output logic fsync
);
    // pol = 1 inverts: the active level becomes low
    assign fsync = act ^ pol;
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
    import audio_clkgen_pkg::*;
#(
    parameter int DIV_W = DIV_W_D,
    parameter int WID_W = WID_W_D,
    parameter int PER_W = PER_W_D,
    parameter int CFG_W = CFG_W_D
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             gen_run,
    input  logic             fs_run,
    input  logic             fs_pol,
    input  logic             data_load,
    output logic             bclk,
    output logic             bclk_en,
    output logic             fsync,
    output logic             frame_start
);
    localparam int WID_LSB  = DIV_W;
    localparam int PER_LSB  = WID_LSB + WID_W;
    localparam int MODE_BIT = PER_LSB + PER_W;

    logic [DIV_W-1:0] f_div;
    logic [WID_W-1:0] f_width;
    logic [PER_W-1:0] f_period;
    logic             f_periodic;
    logic             clk_on;
    logic             tick;
    logic             fs_act;
    // Source-select and reserved bits: no function here
    logic [CFG_W-1:MODE_BIT+1] cfg_unused;

    assign f_div      = cfg_word[DIV_W-1:0];
    assign f_width    = cfg_word[WID_LSB +: WID_W];
    assign f_period   = cfg_word[PER_LSB +: PER_W];
    assign f_periodic = cfg_word[MODE_BIT];
    assign cfg_unused = cfg_word[CFG_W-1:MODE_BIT+1];

    acg_divider #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (clk_on),
        .div   (f_div),
        .tick  (tick),
        .level (bclk)
    );

    acg_frame_seq #(.WID_W(WID_W), .PER_W(PER_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .gen_run     (gen_run),
        .fs_run      (fs_run),
        .periodic    (f_periodic),
        .load        (data_load),
        .tick        (tick),
        .width       (f_width),
        .period      (f_period),
        .clk_on      (clk_on),
        .fs_act      (fs_act),
        .frame_start (frame_start)
    );

    acg_fs_drive u_drv (
        .act   (fs_act),
        .pol   (fs_pol),
        .fsync (fsync)
    );

    assign bclk_en = tick;

endmodule

// File: rtl/acg_checker.sv
module acg_checker #(
    parameter int DIV_W = audio_clkgen_pkg::DIV_W_D
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DIV_W-1:0] div_field,
    input logic             gen_run,
    input logic             fs_run,
    input logic             fs_pol,
    input logic             bclk,
    input logic             bclk_en,
    input logic             fsync,
    input logic             frame_start
);
    // R1
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_run |=> (!bclk_en && !frame_start));

    // R3
    halt_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_run |=> !bclk);

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk_en && div_field != '0) |=> (!bclk_en || div_field == '0));

    // R6
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_run |=> (fsync == fs_pol));

    // R7
    start_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (fsync != fs_pol));

    // R10
    fs_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fs_run |=> (!frame_start && fsync == fs_pol));
endmodule

bind audio_clkgen acg_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .div_field   (cfg_word[7:0]),
    .gen_run     (gen_run),
    .fs_run      (fs_run),
    .fs_pol      (fs_pol),
    .bclk        (bclk),
    .bclk_en     (bclk_en),
    .fsync       (fsync),
    .frame_start (frame_start)
);

// File: tb/audio_clkgen_bench.sv
module audio_clkgen_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] cfg_word;
    logic        gen_run, fs_run, fs_pol, data_load;
    logic        bclk, bclk_en, fsync, frame_start;

    int n_vec = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    audio_clkgen u_audio_clkgen (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_word    (cfg_word),
        .gen_run     (gen_run),
        .fs_run      (fs_run),
        .fs_pol      (fs_pol),
        .data_load   (data_load),
        .bclk        (bclk),
        .bclk_en     (bclk_en),
        .fsync       (fsync),
        .frame_start (frame_start)
    );

    function automatic logic [31:0] mk(input int dv, input int w, input int p,
                                       input bit per, input bit src);
        logic [31:0] c;
        c = '0;
        c[7:0]   = dv[7:0];
        c[15:8]  = w[7:0];
        c[27:16] = p[11:0];
        c[28]    = per;
        c[29]    = src;
        return c;
    endfunction

    function automatic logic sig(input int sel);
        return (sel == 0) ? bclk_en : frame_start;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Cycles from one strobe of the selected signal to the next
    task automatic gap(input int sel, output int n);
        int g;
        g = 0;
        while (!sig(sel) && g < 20000) begin @(negedge clk); g++; end
        n = 0;
        do begin @(negedge clk); n++; end while (!sig(sel) && n < 20000);
    endtask

    // Count strobes of the selected signal over a window
    task automatic count(input int sel, input int len, output int n);
        n = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (sig(sel)) n++;
        end
    endtask

    // Wait for frame_start, then length of active fsync in cycles
    task automatic active_len(output int n);
        int g;
        g = 0;
        while (!frame_start && g < 20000) begin @(negedge clk); g++; end
        n = 0;
        while (fsync != fs_pol && n < 20000) begin n++; @(negedge clk); end
    endtask

    task automatic t_reset;
        rst_n = 1'b0; gen_run = 1'b0; fs_run = 1'b0; fs_pol = 1'b0;
        data_load = 1'b0; cfg_word = mk(3, 15, 31, 1'b1, 1'b0);
        cyc(3);
        check("R1 bclk_en in reset", bclk_en, 0);
        check("R1 bclk in reset", bclk, 0);
        check("R1 frame_start in reset", frame_start, 0);
        check("R6 fsync idle high-active", fsync, 0);
        rst_n = 1'b1;
        cyc(2);
        fs_pol = 1'b1;
        cyc(1);
        check("R6 fsync idle low-active", fsync, 1);
        fs_pol = 1'b0;
    endtask

    task automatic t_halt;
        int n;
        fs_run = 1'b1;
        count(0, 100, n);
        check("R1 no bclk_en while gen_run low", n, 0);
        fs_run = 1'b1;
        count(1, 100, n);
        check("R8 no frame sync before generator", n, 0);
        check("R8 fsync inactive before generator", fsync, 0);
        fs_run = 1'b0;
    endtask

    task automatic t_divider;
        int n;
        int hi;
        gen_run = 1'b1;
        cfg_word = mk(3, 15, 31, 1'b1, 1'b0);
        gap(0, n); gap(0, n);
        check("R2 div=3 spacing", n, 4);
        // bclk rises on the cycle after a tick
        hi = 0;
        for (int i = 0; i < 4; i++) begin @(negedge clk); if (bclk) hi++; end
        check("R3 div=3 high cycles", hi, 2);
        cfg_word = mk(4, 15, 31, 1'b1, 1'b0);
        gap(0, n); gap(0, n);
        check("R2 div=4 spacing", n, 5);
        hi = 0;
        for (int i = 0; i < 5; i++) begin @(negedge clk); if (bclk) hi++; end
        check("R3 div=4 high cycles", hi, 3);
        cfg_word = mk(0, 15, 31, 1'b1, 1'b0);
        gap(0, n); gap(0, n);
        check("R2 div=0 spacing", n, 1);
        cfg_word = mk(255, 15, 31, 1'b1, 1'b0);
        gap(0, n); gap(0, n);
        check("R2 div=255 spacing", n, 256);
    endtask

    task automatic t_periodic;
        int n;
        cfg_word = mk(1, 15, 31, 1'b1, 1'b0);
        cyc(3);
        fs_run = 1'b1;
        gap(1, n); gap(1, n);
        check("R4 frame of 32 bits at div=1", n, 64);
        active_len(n);
        check("R5 width 16 bits at div=1", n, 32);
        active_len(n);
        cyc(0);
        // now check strobe alignment on the next frame
        while (!frame_start) @(negedge clk);
        check("R7 fsync active with strobe", fsync, 1);
        @(negedge clk);
        check("R7 strobe one cycle", frame_start, 0);
    endtask

    task automatic t_sizes;
        int n;
        cfg_word = mk(0, 15, 32, 1'b1, 1'b0);
        gap(1, n); gap(1, n);
        check("R4 minimum 33-bit frame", n, 33);
        active_len(n);
        check("R5 width 16 at div=0", n, 16);
        cfg_word = mk(0, 31, 4094, 1'b1, 1'b0);
        gap(1, n); gap(1, n);
        check("R4 maximum 4095-bit frame", n, 4095);
        active_len(n);
        check("R5 width 32 at div=0", n, 32);
    endtask

    task automatic t_polarity;
        int n;
        fs_run = 1'b0;
        cyc(2);
        fs_pol = 1'b1;
        cfg_word = mk(1, 7, 39, 1'b1, 1'b0);
        cyc(2);
        fs_run = 1'b1;
        active_len(n);
        check("R6 active-low width 8 at div=1", n, 16);
        check("R6 idle level high after pulse", fsync, 1);
        fs_run = 1'b0;
        cyc(2);
        fs_pol = 1'b0;
    endtask

    task automatic t_srcbit;
        int n;
        cfg_word = mk(1, 15, 31, 1'b1, 1'b1);
        cyc(2);
        fs_run = 1'b1;
        gap(1, n); gap(1, n);
        check("R11 source bit set, frame", n, 64);
        gap(0, n); gap(0, n);
        check("R11 source bit set, bit clock", n, 2);
    endtask

    task automatic t_fsstop;
        int n;
        while (!frame_start) @(negedge clk);
        fs_run = 1'b0;
        @(negedge clk);
        check("R10 fsync inactive after stop", fsync, 0);
        count(1, 200, n);
        check("R10 no frame_start after stop", n, 0);
        count(0, 20, n);
        check("R10 bit clock keeps running", n, 10);
    endtask

    task automatic t_oneshot;
        int n;
        cfg_word = mk(2, 7, 63, 1'b0, 1'b0);
        cyc(2);
        fs_run = 1'b1;
        count(1, 300, n);
        check("R9 silent without load", n, 0);
        check("R9 fsync idle without load", fsync, 0);
        data_load = 1'b1;
        @(negedge clk);
        data_load = 1'b0;
        active_len(n);
        check("R9 one-shot width 8 at div=2", n, 24);
        count(1, 300, n);
        check("R9 only one pulse per load", n, 0);
        fs_run = 1'b0;
    endtask

    task automatic t_midreset;
        cfg_word = mk(1, 15, 31, 1'b1, 1'b0);
        fs_run = 1'b1;
        while (!frame_start) @(negedge clk);
        cyc(2);
        rst_n = 1'b0;
        #1;
        check("R1 async reset clears fsync", fsync, 0);
        check("R1 async reset clears bclk_en", bclk_en, 0);
        @(negedge clk);
        check("R1 bclk low in reset", bclk, 0);
        rst_n = 1'b1;
        gen_run = 1'b0;
        fs_run = 1'b0;
        cyc(2);
    endtask

    initial begin
        t_reset();
        t_halt();
        t_divider();
        t_periodic();
        t_sizes();
        t_polarity();
        t_srcbit();
        t_fsstop();
        t_oneshot();
        t_midreset();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    initial begin
        #1500000;
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end
endmodule